// File: doc/BRIEF.md
# Punched Tape Line Reader Interface

This block sits between a line-at-a-time punched tape reader and a 36-bit in-out register. The processor issues a transfer request with a function code. Code 1 reads a single character. Code 2 reads a packed binary word. The reader is seen as an 8-bit line bus and a one-cycle strobe for each line. The block collects the lines into the register, reports the odd-parity status of a character, and raises a one-cycle completion pulse.

A character transfer ends on the first line strobe after it starts. A binary transfer keeps only the lines whose top hole (bit 7) is punched. It takes six bits from each such line and ends after six of them. When the halt bit of the request is set, a wait output stays high until the transfer finishes. A request that arrives while a transfer is running is dropped and flagged.

Top module: `tape_rdr_if`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, io_reg_o is 0 and done_o, busy_o, wait_o, err_o and parity_ok_o are 0.
- R2: A request seen while idle with function code 1 or 2 sets busy_o and clears io_reg_o in the next cycle. A request with any other code has no effect.
- R3: In character mode (code 1), the first line strobe after the start loads the 8 line bits into io_reg_o[7:0], forces io_reg_o[35:8] to 0 and ends the transfer.
- R4: parity_ok_o is 1 after a character whose 8 bits hold an odd number of ones, and 0 otherwise. It is 0 during and after a binary transfer.
- R5: In binary mode (code 2), each accepted line shifts io_reg_o left by 6 and puts line bits [5:0] in io_reg_o[5:0]. After six accepted lines, the first one sits in bits [35:30] and the transfer ends.
- R6: In binary mode, a strobed line with bit 7 clear leaves the register and the line count unchanged.
- R7: done_o is high for exactly one cycle, the cycle after the capturing strobe. busy_o falls in that same cycle.
- R8: While no transfer is running and no request is presented, io_reg_o holds its value.
- R9: A request while busy_o is high does not alter the running transfer and sets err_o in the next cycle. err_o stays set until the next accepted request clears it.
- R10: wait_o is high for the whole of a transfer whose request had the halt bit set, and is low otherwise.
- R11: Line strobes while idle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| xfer_req_i | input | 1 | Transfer request pulse |
| xfer_fn_i | input | 6 | Function code from the instruction address field |
| xfer_halt_i | input | 1 | Halt-until-complete request bit |
| line_stb_i | input | 1 | Reader line strobe, one cycle per line |
| line_i | input | 8 | Tape line, bit 7 is the eighth hole |
| io_reg_o | output | 36 | In-out register |
| done_o | output | 1 | Completion pulse |
| busy_o | output | 1 | Transfer in progress |
| wait_o | output | 1 | Processor hold for halt transfers |
| parity_ok_o | output | 1 | Odd parity of the last character |
| err_o | output | 1 | Overlapping request seen |

## Verification
The bench reads characters with an even and an odd number of ones, to tell the parity flag from a copy of the low bit. Binary words use distinct 6-bit values per line, so a wrong shift order or a wrong line count shows up in the final word. Lines with bit 7 clear are mixed into a binary word, and strobes and bad function codes are sent while idle, to show that these are ignored. One binary word is read with a 20000-cycle gap between lines, to model the slow reader rate.

// File: rtl/tape_rdr_pkg.sv
package tape_rdr_pkg;
  localparam int unsigned WORD_W   = 36;
  localparam int unsigned LINE_W   = 8;
  localparam int unsigned BIN_BITS = 6;
  localparam int unsigned FN_W     = 6;
  localparam logic [FN_W-1:0] FN_CHAR = FN_W'(1);
  localparam logic [FN_W-1:0] FN_BIN  = FN_W'(2);
endpackage

// File: rtl/tape_rdr_ctrl.sv
module tape_rdr_ctrl #(
  parameter int unsigned FN_W  = 6,
  parameter int unsigned LINES = 6,
  parameter logic [FN_W-1:0] FN_CHAR = FN_W'(1),
  parameter logic [FN_W-1:0] FN_BIN  = FN_W'(2)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [FN_W-1:0] fn_i,
  input  logic            halt_i,
  input  logic            stb_i,
  input  logic            hole8_i,
  output logic            start_o,
  output logic            load_char_o,
  output logic            shift_o,
  output logic            bin_o,
  output logic            busy_o,
  output logic            wait_o,
  output logic            done_o,
  output logic            err_o
);
  localparam int unsigned CNT_W = (LINES > 1) ? $clog2(LINES) : 1;

  logic             busy_q, bin_q, halt_q, done_q, err_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fn_ok, cap, last;

  assign fn_ok       = (fn_i == FN_CHAR) || (fn_i == FN_BIN);
  assign start_o     = !busy_q && req_i && fn_ok;
  assign cap         = busy_q && stb_i && (!bin_q || hole8_i);
  assign load_char_o = cap && !bin_q;
  assign shift_o     = cap && bin_q;
  assign last        = load_char_o || (shift_o && cnt_q == CNT_W'(LINES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      bin_q  <= 1'b0;
      halt_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= last;
      if (start_o) begin
        busy_q <= 1'b1;
        bin_q  <= (fn_i == FN_BIN);
        halt_q <= halt_i;
        err_q  <= 1'b0;
        cnt_q  <= '0;
      end else begin
        if (busy_q && req_i) err_q <= 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          halt_q <= 1'b0;
          cnt_q  <= '0;
        end else if (shift_o) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign bin_o  = bin_q;
  assign busy_o = busy_q;
  assign wait_o = busy_q && halt_q;
  assign done_o = done_q;
  assign err_o  = err_q;

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(LINES));
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_err_overlap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_i) |=> err_o);
  p_wait_in_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |-> busy_o);
endmodule

// File: rtl/tape_rdr_shreg.sv
module tape_rdr_shreg #(
  parameter int unsigned WORD_W   = 36,
  parameter int unsigned LINE_W   = 8,
  parameter int unsigned BIN_BITS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              load_char_i,
  input  logic              shift_i,
  input  logic [LINE_W-1:0] line_i,
  output logic [WORD_W-1:0] word_o,
  output logic              parity_ok_o
);
  logic [WORD_W-1:0] word_q;
  logic              par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      par_q  <= 1'b0;
    end else if (clear_i) begin
      word_q <= '0;
      par_q  <= 1'b0;
    end else if (load_char_i) begin
      word_q <= WORD_W'(line_i);
      par_q  <= ^line_i;
    end else if (shift_i) begin
      word_q <= {word_q[WORD_W-BIN_BITS-1:0], line_i[BIN_BITS-1:0]};
    end
  end

  assign word_o      = word_q;
  assign parity_ok_o = par_q;

  p_hold_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clear_i || load_char_i || shift_i) |=> $stable(word_o));
endmodule

// File: rtl/tape_rdr_if.sv
module tape_rdr_if
  import tape_rdr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_req_i,
  input  logic [FN_W-1:0]   xfer_fn_i,
  input  logic              xfer_halt_i,
  input  logic              line_stb_i,
  input  logic [LINE_W-1:0] line_i,
  output logic [WORD_W-1:0] io_reg_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              wait_o,
  output logic              parity_ok_o,
  output logic              err_o
);
  localparam int unsigned LINES = WORD_W / BIN_BITS;

  logic start, load_char, shift, bin_mode;

  tape_rdr_ctrl #(
    .FN_W(FN_W), .LINES(LINES), .FN_CHAR(FN_CHAR), .FN_BIN(FN_BIN)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .req_i(xfer_req_i), .fn_i(xfer_fn_i), .halt_i(xfer_halt_i),
    .stb_i(line_stb_i), .hole8_i(line_i[LINE_W-1]),
    .start_o(start), .load_char_o(load_char), .shift_o(shift),
    .bin_o(bin_mode), .busy_o, .wait_o, .done_o, .err_o
  );

  tape_rdr_shreg #(
    .WORD_W(WORD_W), .LINE_W(LINE_W), .BIN_BITS(BIN_BITS)
  ) u_shreg (
    .clk_i, .rst_ni,
    .clear_i(start), .load_char_i(load_char), .shift_i(shift),
    .line_i, .word_o(io_reg_o), .parity_ok_o
  );

  p_char_upper_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !bin_mode) |-> (io_reg_o[WORD_W-1:LINE_W] == '0));
  p_bin_no_parity_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && bin_mode) |-> !parity_ok_o);
  p_idle_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !xfer_req_i) |=> $stable(io_reg_o));
  p_done_ends_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: tb/tape_rdr_if_tb.sv
module tape_rdr_if_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, halt = 1'b0, stb = 1'b0;
  logic [5:0]  fn = '0;
  logic [7:0]  line = '0;
  logic [35:0] io_reg;
  logic        done, busy, wt, par, err;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  tape_rdr_if dut_i (
    .clk_i(clk), .rst_ni(rst_n), .xfer_req_i(req), .xfer_fn_i(fn),
    .xfer_halt_i(halt), .line_stb_i(stb), .line_i(line),
    .io_reg_o(io_reg), .done_o(done), .busy_o(busy), .wait_o(wt),
    .parity_ok_o(par), .err_o(err)
  );

  // behavioural reference model
  logic [35:0] m_reg;
  logic        m_busy, m_bin, m_wait, m_done, m_par, m_err;
  int          m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = '0; m_busy = 0; m_bin = 0; m_wait = 0;
      m_done = 0; m_par = 0; m_err = 0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (req) m_err = 1;
        if (stb) begin
          if (!m_bin) begin
            m_reg = {28'b0, line}; m_par = ^line;
            m_done = 1; m_busy = 0; m_wait = 0;
          end else if (line[7]) begin
            m_reg = {m_reg[29:0], line[5:0]};
            m_cnt++;
            if (m_cnt == 6) begin
              m_done = 1; m_busy = 0; m_wait = 0; m_cnt = 0;
            end
          end
        end
      end else if (req && (fn == 6'd1 || fn == 6'd2)) begin
        m_busy = 1; m_bin = (fn == 6'd2); m_reg = '0;
        m_par = 0; m_err = 0; m_cnt = 0; m_wait = halt;
      end
    end
  end

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    chk("R3/R5 io_reg", io_reg, m_reg);
    chk("R7 done", 36'(done), 36'(m_done));
    chk("R2 busy", 36'(busy), 36'(m_busy));
    chk("R10 wait", 36'(wt), 36'(m_wait));
    chk("R4 parity", 36'(par), 36'(m_par));
    chk("R9 err", 36'(err), 36'(m_err));
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic request(logic [5:0] f, logic h);
    @(negedge clk); req = 1; fn = f; halt = h;
    @(negedge clk); req = 0; fn = '0; halt = 0;
  endtask

  task automatic strobe(logic [7:0] d, int gap);
    @(negedge clk); stb = 1; line = d;
    @(negedge clk); stb = 0; line = '0;
    idle(gap);
  endtask

  initial begin
    idle(3);
    chk("R1 reset reg", io_reg, '0);
    chk("R1 reset flags", 36'({done, busy, wt, par, err}), '0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 after release", 36'({done, busy, wt, par, err}), '0);

    strobe(8'hA5, 2);                                   // R11
    chk("R11 idle strobe", io_reg, '0);
    request(6'd3, 1'b0);                                // R2 bad code
    chk("R2 bad code busy", 36'(busy), '0);

    request(6'd1, 1'b1);                                // char, halt
    chk("R10 wait high", 36'(wt), 36'd1);
    strobe(8'h41, 0);
    chk("R3 char", io_reg, 36'h41);
    chk("R4 even ones", 36'(par), '0);
    idle(5);
    chk("R8 hold", io_reg, 36'h41);

    request(6'd1, 1'b0);
    chk("R10 wait low", 36'(wt), '0);
    chk("R2 cleared", io_reg, '0);
    request(6'd2, 1'b0);                                // overlap
    chk("R9 err set", 36'(err), 36'd1);
    strobe(8'hC1, 0);
    chk("R3 char2", io_reg, 36'hC1);
    chk("R4 odd ones", 36'(par), 36'd1);

    request(6'd2, 1'b1);                                // binary
    chk("R9 err cleared", 36'(err), '0);
    strobe(8'h81, 3);
    strobe(8'h15, 3);                                   // skipped
    chk("R6 skip", io_reg, 36'h1);
    for (int k = 2; k <= 6; k++) strobe(8'h80 | 8'(k), 3);
    chk("R5 word", io_reg, {6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 6'd6});
    chk("R4 binary parity", 36'(par), '0);

    request(6'd2, 1'b0);                                // slow reader
    for (int k = 0; k < 6; k++) strobe(8'hBF - 8'(k), 20000);
    chk("R5 slow word", io_reg, {6'h3F, 6'h3E, 6'h3D, 6'h3C, 6'h3B, 6'h3A});
    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule